// File: doc/BRIEF.md
# Pipelined Carry-Save Tree Multiplier

This block multiplies two 6-bit unsigned operands and returns the 12-bit product through a five-stage pipeline. A new operand pair may be offered on every clock. The first stage expands the pair into six partial-product rows: row k is the multiplicand shifted left by k and gated by bit k of the multiplier. Three stages of 3-to-2 carry-save adders then reduce the six rows to one sum vector and one carry vector. The carry-save adders have no carry chain between bit positions, so each of these stages is only one full adder deep. The last stage adds the two vectors with an ordinary carry-propagate adder.

The reduction uses four carry-save adders. The second stage has two of them, each taking three rows. The third stage merges one full sum/carry pair with the sum of the other pair, and carries the remaining carry vector forward in a register. The fourth stage merges the three vectors that remain. Every carry vector is moved up one bit before the next level uses it. A qualifying valid bit travels with the data. The output keeps its last product while no result is being delivered.

Top module: `csm_mult`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, out_valid is 0 and out_prod is 0.
- R2: For each accepted pair, out_prod equals in_a × in_b as an unsigned 12-bit value.
- R3: When in_valid is high at a rising edge, out_valid is high and the result is on out_prod after the fifth rising edge from that one. When in_valid is low at that edge, out_valid is low after the fifth edge.
- R4: Pairs offered on consecutive cycles give results on consecutive cycles, in the same order.
- R5: Idle cycles (in_valid low) between pairs show up as the same pattern of idle output cycles.
- R6: Operands presented while in_valid is low are ignored. On any cycle where out_valid is low, out_prod holds the value it had on the cycle before.
- R7: The sum and carry vectors leaving each carry-save level keep the value of the vectors that entered it, modulo 2^12.
- R8: The extreme cases give exact results: 63 × 63 = 3969, and any operand times 0 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair on in_a/in_b is to be multiplied |
| in_a | input | 6 | Multiplicand, unsigned |
| in_b | input | 6 | Multiplier, unsigned |
| out_valid | output | 1 | out_prod carries a new result this cycle |
| out_prod | output | 12 | Unsigned product |

## Verification
The end-to-end assertions compare each result with the operands seen five edges earlier. They therefore assume that in_a, in_b and in_valid are all sampled at every edge, and they stay silent until five edges have passed since reset. The bench drives the inputs only on falling edges, so each value is stable around the rising edge that samples it. It also holds reset long enough that no pre-reset activity falls inside that five-edge window. The operand buses are left free to change during idle cycles, so that the claim that they are ignored is actually tested.

// File: rtl/csm_pkg.sv
package csm_pkg;
    localparam int OPW  = 6;
    localparam int PRW  = 2 * OPW;
    localparam int ROWS = OPW;
    localparam int LAT  = 5;

    typedef logic [OPW-1:0] opnd_t;
    typedef logic [PRW-1:0] vec_t;
    typedef logic [ROWS-1:0][PRW-1:0] rows_t;

    typedef struct packed {
        logic  vld;
        rows_t rows;
    } st_pp_t;

    typedef struct packed {
        logic vld;
        vec_t s_lo;
        vec_t c_lo;
        vec_t s_hi;
        vec_t c_hi;
    } st_l1_t;

    typedef struct packed {
        logic vld;
        vec_t s;
        vec_t c;
        vec_t extra;
    } st_l2_t;

    typedef struct packed {
        logic vld;
        vec_t s;
        vec_t c;
    } st_l3_t;

    typedef struct packed {
        logic vld;
        vec_t prod;
    } st_out_t;

    function automatic vec_t widen(input opnd_t x);
        return vec_t'(x);
    endfunction
endpackage

// File: rtl/csm_ppgen.sv
module csm_ppgen
    import csm_pkg::*;
(
    input  opnd_t mcand,
    input  opnd_t mplier,
    output rows_t rows
);
    vec_t base;
    assign base = widen(mcand);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign rows[r] = mplier[r] ? (base << r) : '0;
    end
endmodule

// File: rtl/csm_csa.sv
module csm_csa #(
    parameter int W = 12
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] sum,
    output logic [W-1:0] cry
);
    logic [W-1:0] maj;

    always_comb begin
        sum = x ^ y ^ z;
        maj = (x & y) | (x & z) | (y & z);
        cry = maj << 1;
    end
endmodule

// File: rtl/csm_cpa.sv
module csm_cpa #(
    parameter int W = 12
) (
    input  logic [W-1:0] s,
    input  logic [W-1:0] c,
    output logic [W-1:0] total
);
    assign total = s + c;
endmodule

// File: rtl/csm_mult.sv
module csm_mult
    import csm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OPW-1:0]    in_a,
    input  logic [OPW-1:0]    in_b,
    output logic              out_valid,
    output logic [PRW-1:0]    out_prod
);
    st_pp_t  pp_q;
    st_l1_t  l1_q;
    st_l2_t  l2_q;
    st_l3_t  l3_q;
    st_out_t out_q;

    // Stage 1: partial-product rows
    rows_t rows_d;
    csm_ppgen u_pp (.mcand(in_a), .mplier(in_b), .rows(rows_d));

    always_ff @(posedge clk) begin
        if (rst) begin
            pp_q <= '0;
        end else begin
            pp_q.vld <= in_valid;
            if (in_valid) pp_q.rows <= rows_d;
        end
    end

    // Stage 2: two carry-save adders, rows 0..2 and 3..5
    vec_t s_lo_d, c_lo_d, s_hi_d, c_hi_d;
    csm_csa #(.W(PRW)) u_csa_lo (.x(pp_q.rows[0]), .y(pp_q.rows[1]), .z(pp_q.rows[2]),
                                 .sum(s_lo_d), .cry(c_lo_d));
    csm_csa #(.W(PRW)) u_csa_hi (.x(pp_q.rows[3]), .y(pp_q.rows[4]), .z(pp_q.rows[5]),
                                 .sum(s_hi_d), .cry(c_hi_d));

    always_ff @(posedge clk) begin
        if (rst) begin
            l1_q <= '0;
        end else begin
            l1_q.vld <= pp_q.vld;
            if (pp_q.vld) begin
                l1_q.s_lo <= s_lo_d;
                l1_q.c_lo <= c_lo_d;
                l1_q.s_hi <= s_hi_d;
                l1_q.c_hi <= c_hi_d;
            end
        end
    end

    // Stage 3: one carry-save adder, leftover carry vector registered
    vec_t s_m_d, c_m_d;
    csm_csa #(.W(PRW)) u_csa_mid (.x(l1_q.s_lo), .y(l1_q.c_lo), .z(l1_q.s_hi),
                                  .sum(s_m_d), .cry(c_m_d));

    always_ff @(posedge clk) begin
        if (rst) begin
            l2_q <= '0;
        end else begin
            l2_q.vld <= l1_q.vld;
            if (l1_q.vld) begin
                l2_q.s     <= s_m_d;
                l2_q.c     <= c_m_d;
                l2_q.extra <= l1_q.c_hi;
            end
        end
    end

    // Stage 4: last carry-save adder
    vec_t s_f_d, c_f_d;
    csm_csa #(.W(PRW)) u_csa_fin (.x(l2_q.s), .y(l2_q.c), .z(l2_q.extra),
                                  .sum(s_f_d), .cry(c_f_d));

    always_ff @(posedge clk) begin
        if (rst) begin
            l3_q <= '0;
        end else begin
            l3_q.vld <= l2_q.vld;
            if (l2_q.vld) begin
                l3_q.s <= s_f_d;
                l3_q.c <= c_f_d;
            end
        end
    end

    // Stage 5: carry-propagate add
    vec_t prod_d;
    csm_cpa #(.W(PRW)) u_cpa (.s(l3_q.s), .c(l3_q.c), .total(prod_d));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.vld <= l3_q.vld;
            if (l3_q.vld) out_q.prod <= prod_d;
        end
    end

    assign out_valid = out_q.vld;
    assign out_prod  = out_q.prod;

    // Cycles since reset, saturating; gates the end-to-end checks
    logic [2:0] warm_cnt;
    always_ff @(posedge clk) begin
        if (rst)                    warm_cnt <= '0;
        else if (warm_cnt != 3'(LAT)) warm_cnt <= warm_cnt + 3'd1;
    end
    logic warm;
    assign warm = (warm_cnt == 3'(LAT));

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_prod == '0)); // R1

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_valid == $past(in_valid, 5))); // R3

    AST_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid) |-> (out_prod == (widen($past(in_a, 5)) * widen($past(in_b, 5))))); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (warm && !out_valid) |-> $stable(out_prod)); // R6

    AST_MID_CONSERVE: assert property (@(posedge clk) disable iff (rst)
        l2_q.vld |-> (vec_t'(l2_q.s + l2_q.c + l2_q.extra) ==
                      $past(vec_t'(l1_q.s_lo + l1_q.c_lo + l1_q.s_hi + l1_q.c_hi)))); // R7

    AST_FIN_CONSERVE: assert property (@(posedge clk) disable iff (rst)
        l3_q.vld |-> (vec_t'(l3_q.s + l3_q.c) ==
                      $past(vec_t'(l2_q.s + l2_q.c + l2_q.extra)))); // R7
endmodule

// File: tb/csm_mult_tb.sv
`timescale 1ns/1ps
module csm_mult_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [5:0]  in_a = '0;
    logic [5:0]  in_b = '0;
    logic        out_valid;
    logic [11:0] out_prod;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;
    bit chk_en = 1'b0;

    always #4 clk = ~clk;

    csm_mult dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_prod(out_prod)
    );

    // Expected-result delay line: 4 stages plus an output holder
    logic        ev [4];
    logic [11:0] ep [4];
    logic        m_v;
    logic [11:0] m_p;
    logic [5:0]  ea [4];
    logic [5:0]  eb [4];
    logic [5:0]  m_a, m_b;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin ev[i] <= 1'b0; ep[i] <= '0; ea[i] <= '0; eb[i] <= '0; end
            m_v <= 1'b0; m_p <= '0; m_a <= '0; m_b <= '0;
        end else begin
            ev[0] <= in_valid;
            ep[0] <= 12'(in_a) * 12'(in_b);
            ea[0] <= in_a; eb[0] <= in_b;
            for (int i = 1; i < 4; i++) begin
                ev[i] <= ev[i-1]; ep[i] <= ep[i-1]; ea[i] <= ea[i-1]; eb[i] <= eb[i-1];
            end
            m_v <= ev[3];
            if (ev[3]) begin m_p <= ep[3]; m_a <= ea[3]; m_b <= eb[3]; end
        end
    end

    always @(negedge clk) begin
        if (chk_en) begin
            if (rst) begin
                checks++;
                if (out_valid !== 1'b0 || out_prod !== 12'd0) begin
                    bad++;
                    $display("FAIL R1 reset: valid=%0b prod=%0d expected valid=0 prod=0", out_valid, out_prod);
                end
            end else begin
                checks++;
                if (out_valid !== m_v) begin
                    bad++;
                    $display("FAIL R3/R5 valid timing: got %0b expected %0b", out_valid, m_v);
                end
                checks++;
                if (out_prod !== m_p) begin
                    bad++;
                    if (!m_v)
                        $display("FAIL R6 hold: prod=%0d expected %0d", out_prod, m_p);
                    else if (m_a == 6'd63 && m_b == 6'd63 || m_a == 0 || m_b == 0)
                        $display("FAIL R8 %0d*%0d: prod=%0d expected %0d", m_a, m_b, out_prod, m_p);
                    else
                        $display("FAIL R2 %0d*%0d: prod=%0d expected %0d", m_a, m_b, out_prod, m_p);
                end
            end
        end
    end

    task automatic step(input logic v, input logic [5:0] a, input logic [5:0] b);
        @(negedge clk);
        in_valid = v; in_a = a; in_b = b;
    endtask

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        @(posedge clk);
        chk_en = 1'b1;
        repeat (3) @(posedge clk);           // R1 checked during reset
        @(negedge clk);
        rst = 1'b0;                          // R1: first cycle after release checked too

        // R2/R4: every operand pair, back to back
        for (int a = 0; a < 64; a++)
            for (int b = 0; b < 64; b++)
                step(1'b1, 6'(a), 6'(b));

        // R5/R6: random gaps with operands changing while idle
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] & lfsr[5], lfsr[11:6], lfsr[15:10]);
        end

        // R8: extreme pairs isolated by idle cycles
        step(1'b1, 6'd63, 6'd63);
        repeat (6) step(1'b0, 6'd17, 6'd42);
        step(1'b1, 6'd0, 6'd63);
        repeat (6) step(1'b0, 6'd63, 6'd63);
        step(1'b1, 6'd63, 6'd0);
        repeat (6) step(1'b0, 6'd5, 6'd9);

        // R6: long idle with wiggling operands, product must hold
        for (int i = 0; i < 20; i++) step(1'b0, 6'(i * 3), 6'(63 - i));

        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL R3 watchdog: run did not complete, got hung expected finish");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule